// File: doc/BRIEF.md
# Sliding-Window Sample History Buffer

This block keeps the most recent 1024 audio samples of a stream, 18 bits each, for a correlator that walks the recent history. The caller keeps a signed 16-bit value in the lower bits and zeros in the upper two. The block stores all 18 bits unchanged.

Writes need no address. Each write strobe appends one sample at a position the block tracks itself. The write side never applies back-pressure: every strobe is taken in the cycle it is high, so there is no ready signal.

The read side takes an 8-bit group address and returns four samples in one 72-bit word, one clock later. The address is relative to the newest sample, so address 0 is always the four newest samples, address 1 the next four older, and so on. The storage is split into four banks, and the bank outputs are rotated, so that a group of four can be read in one access whatever the write count modulo 4.

Top module: `sample_window_buf`

## Requirements
- R1: While reset is high at a rising edge, the output word is cleared to zero. Reset also sets the write position to the start, so the first write after reset becomes the newest sample.
- R2: A sample is stored on each rising edge where `wr_en` is high, and the write position advances by one. A cycle with `wr_en` low stores nothing and changes nothing that a read can observe.
- R3: Read address k returns the samples that are 4k, 4k+1, 4k+2 and 4k+3 writes older than the newest one. The newest of the four is in bits 71:54, the next in 53:36, the next in 35:18, and the oldest in 17:0. Each sample keeps all 18 bits as written.
- R4: The read has one clock of latency. `rd_word` changes only at the rising edge after `rd_addr` is presented.
- R5: Reads return the correct lane order for any number of writes modulo 4.
- R6: When a read and a write fall in the same cycle, the read sees the contents and the write position from before that write.
- R7: The write position wraps from 1023 to 0, and relative addresses wrap modulo 1024. Reads therefore always return the latest 1024 samples written, and address 255 bits 17:0 hold the sample 1023 writes older than the newest.
- R8: Reset does not clear the stored samples. After a reset followed by one write, address 0 returns the new sample in the newest lane. The other three lanes hold the samples stored before the reset at positions 1023, 1022 and 1021.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Sample strobe; stores `wr_sample` at this edge |
| wr_sample | input | 18 | Sample to append |
| rd_addr | input | 8 | Group address, counted back from the newest sample |
| rd_word | output | 72 | Four samples, newest in the top lane |

## Verification
Every read result is due one rising edge after its address is presented, and it reflects the contents and write position from before any write in that same cycle. The bench drives inputs on the falling edge and works out the expected word from its own sample model before it applies that cycle's write. It compares the output at the next falling edge. For R4 it also samples just after a new address is driven, before the edge, and expects the previous result to still be present.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int SAMPLE_W_DEF   = 18;
  localparam int DEPTH_LOG2_DEF = 10;
  localparam int LANE_LOG2_DEF  = 2;
endpackage

// File: rtl/swb_wr_ptr.sv
module swb_wr_ptr #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= ptr + PTR_W'(1);
  end

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> ptr == $past(ptr) + PTR_W'(1));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/swb_bank.sv
module swb_bank #(
  parameter int SAMPLE_W = 18,
  parameter int ROW_W    = 8,
  localparam int ROWS    = 1 << ROW_W
) (
  input  logic                clk,
  input  logic                we,
  input  logic [ROW_W-1:0]    wrow,
  input  logic [SAMPLE_W-1:0] wdata,
  input  logic [ROW_W-1:0]    rrow,
  output logic [SAMPLE_W-1:0] rdata
);
  logic [SAMPLE_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= wdata;
  end

  assign rdata = mem[rrow];
endmodule

// File: rtl/swb_lane_rotate.sv
module swb_lane_rotate #(
  parameter int SAMPLE_W  = 18,
  parameter int LANE_LOG2 = 2,
  localparam int LANES    = 1 << LANE_LOG2
) (
  input  logic [LANES-1:0][SAMPLE_W-1:0] bank_data,
  input  logic [LANE_LOG2-1:0]           newest_bank,
  output logic [LANES*SAMPLE_W-1:0]      word
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_LOG2-1:0] src;
    assign src = newest_bank - LANE_LOG2'(j);
    assign word[(LANES-1-j)*SAMPLE_W +: SAMPLE_W] = bank_data[src];
  end
endmodule

// File: rtl/sample_window_buf.sv
module sample_window_buf #(
  parameter int SAMPLE_W   = swb_pkg::SAMPLE_W_DEF,
  parameter int DEPTH_LOG2 = swb_pkg::DEPTH_LOG2_DEF,
  parameter int LANE_LOG2  = swb_pkg::LANE_LOG2_DEF,
  localparam int LANES     = 1 << LANE_LOG2,
  localparam int ROW_W     = DEPTH_LOG2 - LANE_LOG2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SAMPLE_W-1:0]       wr_sample,
  input  logic [ROW_W-1:0]          rd_addr,
  output logic [LANES*SAMPLE_W-1:0] rd_word
);
  logic [DEPTH_LOG2-1:0]         wr_ptr;
  logic [DEPTH_LOG2-1:0]         base;
  logic [LANES-1:0]              bank_we;
  logic [LANES-1:0][SAMPLE_W-1:0] bank_q;
  logic [LANES*SAMPLE_W-1:0]     rot_word;

  swb_wr_ptr #(.PTR_W(DEPTH_LOG2)) u_ptr (
    .clk(clk), .rst(rst), .adv(wr_en), .ptr(wr_ptr)
  );

  // index of the newest sample of the requested group
  assign base = wr_ptr - DEPTH_LOG2'(1) - {rd_addr, {LANE_LOG2{1'b0}}};

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LANE_LOG2-1:0]  lane_off;
    logic [DEPTH_LOG2-1:0] idx;
    assign lane_off   = base[LANE_LOG2-1:0] - LANE_LOG2'(b);
    assign idx        = base - DEPTH_LOG2'(lane_off);
    assign bank_we[b] = wr_en && (wr_ptr[LANE_LOG2-1:0] == LANE_LOG2'(b));

    swb_bank #(.SAMPLE_W(SAMPLE_W), .ROW_W(ROW_W)) u_bank (
      .clk  (clk),
      .we   (bank_we[b]),
      .wrow (wr_ptr[DEPTH_LOG2-1:LANE_LOG2]),
      .wdata(wr_sample),
      .rrow (idx[DEPTH_LOG2-1:LANE_LOG2]),
      .rdata(bank_q[b])
    );
  end

  swb_lane_rotate #(.SAMPLE_W(SAMPLE_W), .LANE_LOG2(LANE_LOG2)) u_rot (
    .bank_data  (bank_q),
    .newest_bank(base[LANE_LOG2-1:0]),
    .word       (rot_word)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_word <= '0;
    else     rd_word <= rot_word;
  end

  // R1
  rst_clears_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_word == '0);

  // R2
  one_bank_write_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_we) == (wr_en ? 1 : 0));

  // R2
  idle_read_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !$past(wr_en) && !$past(rst) && $stable(rd_addr) |=> $stable(rd_word));
endmodule

// File: tb/sample_window_buf_tb.sv
module sample_window_buf_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [17:0] wr_sample = '0;
  logic [7:0]  rd_addr = '0;
  logic [71:0] rd_word;

  int n_checks = 0;
  int n_fail   = 0;
  logic [17:0] model [1024];
  logic [9:0]  mwp = '0;
  int          wcount = 0;

  always #5 clk = ~clk;

  sample_window_buf u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sample(wr_sample),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  function automatic logic [71:0] exp_word(input int k);
    logic [71:0] w;
    for (int j = 0; j < 4; j++) begin
      logic [9:0] idx;
      idx = mwp - 10'(1) - 10'(4*k) - 10'(j);
      w[(3-j)*18 +: 18] = model[idx];
    end
    return w;
  endfunction

  function automatic logic [17:0] pat(input int i);
    return 18'(i*37 + 18'h2A5A5) ^ 18'(i << 7);
  endfunction

  task automatic check(input logic [71:0] act, input logic [71:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [17:0] d, input int a,
                     input bit chk, input string tag);
    logic [71:0] e;
    wr_en = we; wr_sample = d; rd_addr = 8'(a);
    e = exp_word(a);
    @(posedge clk);
    if (we) begin model[mwp] = d; mwp = mwp + 10'(1); end
    @(negedge clk);
    if (chk) check(rd_word, e, tag);
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, pat(wcount), 0, 1'b0, "");
      wcount++;
    end
    wr_en = 1'b0;
  endtask

  task automatic t_reset_state;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_word, '0, "R1 output zero in reset");
    rst = 1'b0;
    mwp = '0;
  endtask

  task automatic t_fill_and_read;
    write_n(1024);
    cyc(1'b0, '0, 0,   1'b1, "R3 addr 0 after fill");
    cyc(1'b0, '0, 1,   1'b1, "R3 addr 1 after fill");
    cyc(1'b0, '0, 100, 1'b1, "R3 addr 100 after fill");
    cyc(1'b0, '0, 255, 1'b1, "R7 addr 255 after fill");
  endtask

  task automatic t_unaligned;
    write_n(1);
    cyc(1'b0, '0, 0, 1'b1, "R5 one extra write addr 0");
    cyc(1'b0, '0, 7, 1'b1, "R5 one extra write addr 7");
    write_n(2);
    cyc(1'b0, '0, 3, 1'b1, "R5 three extra writes addr 3");
  endtask

  task automatic t_latency;
    logic [71:0] prev;
    cyc(1'b0, '0, 10, 1'b1, "R4 addr 10 settled");
    prev = rd_word;
    rd_addr = 8'd20;
    #1;
    check(rd_word, prev, "R4 no change before edge");
    cyc(1'b0, '0, 20, 1'b1, "R4 addr 20 after edge");
  endtask

  task automatic t_ignored;
    cyc(1'b0, 18'h3FFFF, 0, 1'b0, "");
    cyc(1'b0, 18'h15555, 0, 1'b1, "R2 idle strobe stores nothing addr 0");
    cyc(1'b0, 18'h0AAAA, 1, 1'b1, "R2 idle strobe stores nothing addr 1");
  endtask

  task automatic t_same_cycle;
    cyc(1'b1, 18'h12345, 0, 1'b1, "R6 read sees pre-write state");
    wcount++;
    cyc(1'b0, '0, 0, 1'b1, "R6 next read sees the write");
  endtask

  task automatic t_wrap;
    write_n(301);
    cyc(1'b0, '0, 255, 1'b1, "R7 wrapped addr 255");
    cyc(1'b0, '0, 0,   1'b1, "R7 wrapped addr 0");
  endtask

  task automatic t_keep_contents;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(rd_word, '0, "R1 output cleared by reset mid-run");
    rst = 1'b0;
    mwp = '0;
    write_n(1);
    cyc(1'b0, '0, 0, 1'b1, "R8 contents kept across reset");
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_fill_and_read();
    t_unaligned();
    t_latency();
    t_ignored();
    t_same_cycle();
    t_wrap();
    t_keep_contents();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1ms;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule